// File: doc/BRIEF.md
# Rotated BPSK Header Format Detector

This block decides, from the header OFDM symbol alone, whether an incoming frame uses the high-throughput format or the legacy format. It receives one channel-equalized complex sample per tone. For each sample it forms two single-stream BPSK soft values. The first is taken from the sample as it arrived. The second is taken after the sample is turned by a quarter turn. The magnitudes of both soft values are summed over every tone of the header symbol. When the symbol closes, the two sums are compared and a one-cycle decision pulse reports the format.

Both soft values of every tone are kept in a local cache while the symbol is being received. Once the format is known, the block replays from that cache the soft values of the winning hypothesis, one tone per cycle and in arrival order. It does not recompute them. The header symbol ends either on an explicit end-of-symbol flag or when the cache is full. While the decision and the replay are in progress, the input is held off with a ready signal.

Top module: `hdr_fmt_detect`

## Requirements
- R1: After reset, in_ready is 1, and out_valid and dec_valid are both 0.
- R2: The unrotated soft value of a tone equals its I component. The rotated soft value is the real part of (I + jQ) multiplied by j, which is -Q. Both are sign-extended to SW+1 bits.
- R3: Each hypothesis accumulates the absolute value of its soft value over all tones of the symbol, so negative soft values add to the sum.
- R4: dec_ht is 1, meaning the high-throughput format, only when the rotated sum is strictly greater than the unrotated sum. A tie selects legacy (dec_ht = 0).
- R5: dec_valid is high for exactly one cycle. That cycle immediately follows the clock edge that accepts the closing tone.
- R6: Replay begins in the cycle after dec_valid. It issues one soft value of the chosen hypothesis per cycle, in tone order, with out_valid high throughout and no gaps.
- R7: out_last is 1 only on the final replayed tone of the symbol.
- R8: in_ready is 0 from the closing tone until the replay has finished. Samples offered while in_ready is 0 have no effect on the decision or on the replayed values.
- R9: A symbol closes on an accepted tone with in_last = 1, or on the MAX_TONES-th accepted tone even when in_last is 0.
- R10: A Q value at the most negative code gives a rotated soft value of +2^(SW-1), without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Tone sample present |
| in_ready | output | 1 | Block can accept a tone |
| in_i | input | SW | Equalized in-phase component, signed |
| in_q | input | SW | Equalized quadrature component, signed |
| in_last | input | 1 | Marks the final tone of the header symbol |
| dec_valid | output | 1 | One-cycle pulse carrying the format decision |
| dec_ht | output | 1 | 1 = high-throughput, 0 = legacy |
| out_valid | output | 1 | Replayed soft value present |
| out_soft | output | SW+1 | Replayed soft value of the chosen hypothesis, signed |
| out_last | output | 1 | Final replayed tone |

## Verification
The bench targets the cases a plausible but wrong design would mishandle. A design that sums signed values instead of magnitudes picks the rotated hypothesis on a header whose I components are all large and negative. A design that compares with >= reports high-throughput on an exact tie. A rotation written with the wrong sign, or one that drops the sign extension, replays wrong values and wraps at the most negative Q. Further scenarios cover a single-tone symbol and a full cache that closes without in_last. One scenario offers junk tones during replay: a design that accepts them corrupts the following symbol's decision and replay.

// File: rtl/hfd_pkg.sv
package hfd_pkg;
    localparam int unsigned HFD_SAMPLE_W  = 12;
    localparam int unsigned HFD_MAX_TONES = 64;

    typedef enum logic [1:0] {
        HFD_COLLECT = 2'd0,
        HFD_DECIDE  = 2'd1,
        HFD_REPLAY  = 2'd2
    } hfd_state_e;

    typedef struct packed {
        logic rot_wins;
        logic closing;
    } hfd_evt_t;
endpackage

// File: rtl/hfd_metric.sv
module hfd_metric #(
    parameter int unsigned SW = 12
) (
    input  logic signed [SW-1:0] smp_i,
    input  logic signed [SW-1:0] smp_q,
    output logic signed [SW:0]   soft_plain,
    output logic signed [SW:0]   soft_rot,
    output logic        [SW:0]   mag_plain,
    output logic        [SW:0]   mag_rot
);
    logic signed [SW:0] ext_q;

    always_comb begin
        soft_plain = {smp_i[SW-1], smp_i};
        ext_q      = {smp_q[SW-1], smp_q};
        // a quarter turn sends (I, Q) to (-Q, I)
        soft_rot   = -ext_q;
        mag_plain  = soft_plain[SW] ? $unsigned(-soft_plain) : $unsigned(soft_plain);
        mag_rot    = soft_rot[SW]   ? $unsigned(-soft_rot)   : $unsigned(soft_rot);
    end
endmodule

// File: rtl/hfd_accum.sv
module hfd_accum #(
    parameter int unsigned MW = 13,
    parameter int unsigned GW = 6,
    localparam int unsigned ACCW = MW + GW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add_en,
    input  logic          clr,
    input  logic [MW-1:0] mag_plain,
    input  logic [MW-1:0] mag_rot,
    output logic          rot_wins
);
    logic [ACCW-1:0] acc_plain, acc_rot;
    logic [ACCW-1:0] nxt_plain, nxt_rot;

    always_comb begin
        nxt_plain = acc_plain + {{GW{1'b0}}, mag_plain};
        nxt_rot   = acc_rot   + {{GW{1'b0}}, mag_rot};
        rot_wins  = nxt_rot > nxt_plain;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_plain <= '0;
            acc_rot   <= '0;
        end else if (add_en) begin
            acc_plain <= nxt_plain;
            acc_rot   <= nxt_rot;
        end
    end
endmodule

// File: rtl/hfd_cache.sv
module hfd_cache #(
    parameter int unsigned DW    = 13,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wd_plain,
    input  logic [DW-1:0] wd_rot,
    input  logic [AW-1:0] raddr,
    input  logic          sel_rot,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] bank [2][DEPTH];

    for (genvar h = 0; h < 2; h++) begin : g_bank
        always_ff @(posedge clk) begin
            if (we) bank[h][waddr] <= (h == 0) ? wd_plain : wd_rot;
        end
    end

    assign rdata = bank[sel_rot ? 1 : 0][raddr];
endmodule

// File: rtl/hdr_fmt_detect.sv
module hdr_fmt_detect
    import hfd_pkg::*;
#(
    parameter int unsigned SW        = HFD_SAMPLE_W,
    parameter int unsigned MAX_TONES = HFD_MAX_TONES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [SW-1:0] in_i,
    input  logic signed [SW-1:0] in_q,
    input  logic                 in_last,
    output logic                 dec_valid,
    output logic                 dec_ht,
    output logic                 out_valid,
    output logic signed [SW:0]   out_soft,
    output logic                 out_last
);
    localparam int unsigned AW = $clog2(MAX_TONES);
    localparam int unsigned MW = SW + 1;

    hfd_state_e state;
    logic [AW-1:0] wr_ptr, rd_ptr, last_idx;
    logic          ht_q;
    logic          accept;
    hfd_evt_t      evt;

    logic signed [SW:0] soft_plain, soft_rot;
    logic [MW-1:0]      mag_plain, mag_rot;
    logic [MW-1:0]      rd_word;

    assign in_ready  = (state == HFD_COLLECT);
    assign accept    = in_valid && in_ready;
    assign evt.closing = accept && (in_last || wr_ptr == AW'(MAX_TONES - 1));

    hfd_metric #(.SW(SW)) u_metric (
        .smp_i      (in_i),
        .smp_q      (in_q),
        .soft_plain (soft_plain),
        .soft_rot   (soft_rot),
        .mag_plain  (mag_plain),
        .mag_rot    (mag_rot)
    );

    hfd_accum #(.MW(MW), .GW(AW + 1)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .add_en    (accept),
        .clr       (evt.closing),
        .mag_plain (mag_plain),
        .mag_rot   (mag_rot),
        .rot_wins  (evt.rot_wins)
    );

    hfd_cache #(.DW(MW), .DEPTH(MAX_TONES)) u_cache (
        .clk      (clk),
        .we       (accept),
        .waddr    (wr_ptr),
        .wd_plain (soft_plain),
        .wd_rot   (soft_rot),
        .raddr    (rd_ptr),
        .sel_rot  (ht_q),
        .rdata    (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= HFD_COLLECT;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            last_idx <= '0;
            ht_q     <= 1'b0;
        end else begin
            unique case (state)
                HFD_COLLECT: if (accept) begin
                    if (evt.closing) begin
                        last_idx <= wr_ptr;
                        wr_ptr   <= '0;
                        ht_q     <= evt.rot_wins;
                        state    <= HFD_DECIDE;
                    end else begin
                        wr_ptr <= wr_ptr + 1'b1;
                    end
                end
                HFD_DECIDE: begin
                    rd_ptr <= '0;
                    state  <= HFD_REPLAY;
                end
                HFD_REPLAY: begin
                    if (rd_ptr == last_idx) state <= HFD_COLLECT;
                    else                    rd_ptr <= rd_ptr + 1'b1;
                end
                default: state <= HFD_COLLECT;
            endcase
        end
    end

    assign dec_valid = (state == HFD_DECIDE);
    assign dec_ht    = ht_q;
    assign out_valid = (state == HFD_REPLAY);
    assign out_soft  = $signed(rd_word);
    assign out_last  = out_valid && (rd_ptr == last_idx);
endmodule

// File: rtl/hfd_checker.sv
module hfd_checker (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic dec_valid,
    input logic out_valid,
    input logic out_last
);
    // R5
    dec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    // R6
    replay_start_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> out_valid);

    // R6
    replay_gapless_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    // R7
    last_in_replay_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R8
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_ready, dec_valid, out_valid}));

    // R8
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |=> in_ready);
endmodule

bind hdr_fmt_detect hfd_checker u_hfd_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .dec_valid (dec_valid),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/hdr_fmt_detect_test.sv
module hdr_fmt_detect_test;
    localparam int SW = 12;
    localparam int NT = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_last = 1'b0;
    logic signed [SW-1:0] in_i = '0;
    logic signed [SW-1:0] in_q = '0;
    logic in_ready, dec_valid, dec_ht, out_valid, out_last;
    logic signed [SW:0] out_soft;

    int checks = 0;
    int errors = 0;
    int ti [NT];
    int tq [NT];

    always #4 clk = ~clk;

    hdr_fmt_detect #(.SW(SW), .MAX_TONES(NT)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .in_last(in_last),
        .dec_valid(dec_valid), .dec_ht(dec_ht),
        .out_valid(out_valid), .out_soft(out_soft), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // drives n tones from ti/tq, then checks decision and replay
    task automatic run_symbol(input int n, input bit use_last, input bit junk, input string tag);
        int sp = 0;
        int sr = 0;
        bit exp_ht;
        for (int k = 0; k < n; k++) begin
            sp += iabs(ti[k]);
            sr += iabs(tq[k]);
        end
        exp_ht = (sr > sp);                       // R3 R4
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) chk(in_ready == 1'b1, {tag, " R8 ready"}, int'(in_ready), 1);
            in_valid = 1'b1;
            in_i = SW'(ti[k]);
            in_q = SW'(tq[k]);
            in_last = use_last && (k == n - 1);    // R9 when use_last is 0
        end
        @(negedge clk);
        in_valid = junk;
        in_i = 12'sd999;
        in_q = -12'sd999;
        in_last = 1'b1;
        chk(dec_valid == 1'b1, {tag, " R5 dec_valid"}, int'(dec_valid), 1);
        chk(dec_ht == exp_ht, {tag, " R4 dec_ht"}, int'(dec_ht), int'(exp_ht));
        chk(in_ready == 1'b0, {tag, " R8 busy"}, int'(in_ready), 0);
        for (int k = 0; k < n; k++) begin
            int exp_soft;
            @(negedge clk);
            if (k == n - 1) in_valid = 1'b0;
            exp_soft = exp_ht ? -tq[k] : ti[k];     // R2
            chk(out_valid == 1'b1, {tag, " R6 out_valid"}, int'(out_valid), 1);
            chk(dec_valid == 1'b0, {tag, " R5 single pulse"}, int'(dec_valid), 0);
            chk(int'(out_soft) == exp_soft, {tag, " R2 R6 soft"}, int'(out_soft), exp_soft);
            chk(out_last == (k == n - 1), {tag, " R7 last"}, int'(out_last), int'(k == n - 1));
            chk(in_ready == 1'b0, {tag, " R8 held"}, int'(in_ready), 0);
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, {tag, " R6 end"}, int'(out_valid), 0);
        chk(in_ready == 1'b1, {tag, " R8 reopen"}, int'(in_ready), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(dec_valid == 1'b0, "R1 dec_valid", int'(dec_valid), 0);
    endtask

    task automatic t_plain_wins();
        for (int k = 0; k < 8; k++) begin ti[k] = (k % 2) ? 400 : -350; tq[k] = 20 * k - 70; end
        run_symbol(8, 1'b1, 1'b0, "plain");
    endtask

    task automatic t_rot_wins();
        for (int k = 0; k < 10; k++) begin ti[k] = k - 5; tq[k] = (k % 3 == 0) ? -500 : 450; end
        run_symbol(10, 1'b1, 1'b0, "rotated");
    endtask

    task automatic t_abs_sum();   // R3: signed sums would favour rotation
        for (int k = 0; k < 6; k++) begin ti[k] = -300; tq[k] = 50; end
        run_symbol(6, 1'b1, 1'b0, "R3 magnitude");
    endtask

    task automatic t_tie();       // R4: equal sums give legacy
        for (int k = 0; k < 4; k++) begin ti[k] = (k % 2) ? 77 : -77; tq[k] = (k % 2) ? -77 : 77; end
        run_symbol(4, 1'b1, 1'b0, "R4 tie");
    endtask

    task automatic t_extreme();   // R10
        for (int k = 0; k < 3; k++) begin ti[k] = 1; tq[k] = -2048; end
        run_symbol(3, 1'b1, 1'b0, "R10 min Q");
    endtask

    task automatic t_single();
        ti[0] = -9; tq[0] = 4;
        run_symbol(1, 1'b1, 1'b0, "single tone");
    endtask

    task automatic t_full();      // R9
        for (int k = 0; k < NT; k++) begin ti[k] = (k * 37) % 401 - 200; tq[k] = (k * 53) % 419 - 205; end
        run_symbol(NT, 1'b0, 1'b0, "R9 full cache");
    endtask

    task automatic t_ignored();   // R8: junk offered during replay
        for (int k = 0; k < 5; k++) begin ti[k] = 600; tq[k] = 10; end
        run_symbol(5, 1'b1, 1'b1, "R8 junk offered");
        for (int k = 0; k < 5; k++) begin ti[k] = 5; tq[k] = -(100 + k); end
        run_symbol(5, 1'b1, 1'b0, "R8 after junk");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain_wins();
        t_rot_wins();
        t_abs_sum();
        t_tie();
        t_extreme();
        t_single();
        t_full();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule